// File: doc/BRIEF.md
# Configurable Look-Up-Table Logic Cell

This block is one programmable cell of a cluster-based logic fabric. A 16-bit configuration mask defines any Boolean function of four data inputs. A single-bit register with a full set of control inputs follows the table. The cell runs in one of three ways. It can drive its output straight from the table. It can register the table result. It can register one data input directly and leave the table out of that path.

Two cascade paths let cells be stacked into a column. The table result goes out on a chain output, and the next cell may use that value in place of its lowest data input to build functions wider than four inputs. The register can also take the previous cell's register value, so that a column becomes a shift register. While the register shifts, the table still drives the cell's outputs with an unrelated function.

The register has a clock enable, a synchronous clear and a synchronous load. It also has an asynchronous clear, an asynchronous preset and an asynchronous load, and both loads take their value from a dedicated load-data input.

Top module: `lut_cell`

## Requirements
- R1: `localOut` and `lutChainOut` equal `cfgMask[idx]`, where the 4-bit index `idx` has `dIn[3]` as its most significant bit and `dIn[0]` as its least significant bit.
- R2: While `useLutChain` is 1, `lutChainIn` takes the place of `dIn[0]` as index bit 0. The other three index bits still come from `dIn[3:1]`.
- R3: While `ena` is 0 and no asynchronous control is high, a rising clock edge leaves the register unchanged, whatever the other synchronous controls are.
- R4: With `ena` at 1, `sclr` at 1 clears the register on the clock edge. It wins over `sload`, over the chain and over the normal data.
- R5: With `ena` at 1 and `sclr` at 0, `sload` at 1 loads `aData` into the register on the clock edge. It wins over the chain and over the normal data.
- R6: A rising edge on `aclr` forces the register to 0 at once, with no clock edge needed, and the register stays at 0 while `aclr` is high. `aclr` wins over `apre` and `aload`.
- R7: A rising edge on `apre` (with `aclr` low) forces the register to 1 at once, with no clock edge needed. `apre` wins over `aload`.
- R8: A rising edge on `aload` (with `aclr` and `apre` low) loads `aData` into the register at once, with no clock edge needed. Every clock edge while `aload` stays high reloads `aData`.
- R9: `mode` picks `routeOut`. The value 0 gives the table result without a register. The value 1, and also 3, gives the register, which captures the table result. The value 2 gives the register, which captures `dIn[0]` with the table left out.
- R10: While `useRegChain` is 1, normal data capture takes `regChainIn`. In this state `routeOut` shows the table result without a register, whatever `mode` is.
- R11: `regChainOut` and `regFb` always carry the current register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| cfgMask | input | 16 | Table configuration mask |
| dIn | input | 4 | Data inputs; bit 3 is the most significant index bit |
| lutChainIn | input | 1 | Table result from the previous cell |
| useLutChain | input | 1 | Use `lutChainIn` in place of `dIn[0]` |
| regChainIn | input | 1 | Register value from the previous cell |
| useRegChain | input | 1 | Register shifts from `regChainIn` |
| mode | input | 2 | Output and capture mode |
| ena | input | 1 | Clock enable for all synchronous actions |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load from `aData` |
| aclr | input | 1 | Asynchronous clear |
| apre | input | 1 | Asynchronous preset |
| aload | input | 1 | Asynchronous load from `aData` |
| aData | input | 1 | Load data for both load controls |
| routeOut | output | 1 | Mode-selected output to routing |
| localOut | output | 1 | Table result to local routing |
| lutChainOut | output | 1 | Table result to the next cell |
| regChainOut | output | 1 | Register value to the next cell |
| regFb | output | 1 | Register feedback |

## Verification
The hardest cases to reach are those where asynchronous controls overlap with one another and with the clock. These include clear and preset rising in the same instant, and a load held high across several clock edges while synchronous controls are also active. The stimulus changes the asynchronous inputs at the falling clock edge, so each one first acts without a clock. It then holds them across the next rising edges so that the clock path and the asynchronous path meet. Shift-with-unrelated-function is reached by holding `useRegChain` high and walking the data and mask values while a known bit pattern moves through `regChainIn`.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  typedef enum logic [1:0] {
    MODE_COMB    = 2'd0,
    MODE_REG_LUT = 2'd1,
    MODE_REG_BYP = 2'd2,
    MODE_REG_ALT = 2'd3
  } cellMode_e;

  typedef struct packed {
    logic capture;
    logic clear;
    logic load;
    logic shift;
    logic bypass;
    logic showReg;
  } cellStrobes_t;

endpackage

// File: rtl/lut_cell_ctrl.sv
module lut_cell_ctrl
  import lut_cell_pkg::*;
(
  input  logic         ena,
  input  logic         sclr,
  input  logic         sload,
  input  logic         useRegChain,
  input  logic [1:0]   mode,
  output cellStrobes_t strobes
);

  cellMode_e modeSel;

  always_comb begin
    modeSel         = cellMode_e'(mode);
    strobes.capture = ena;
    strobes.clear   = ena & sclr;
    strobes.load    = ena & ~sclr & sload;
    strobes.shift   = useRegChain;
    strobes.bypass  = (modeSel == MODE_REG_BYP);
    strobes.showReg = ~useRegChain & (modeSel != MODE_COMB);
  end

endmodule

// File: rtl/lut_cell_dp.sv
module lut_cell_dp
  import lut_cell_pkg::*;
#(
  parameter int K = 4,
  localparam int MASK_W = 1 << K
) (
  input  logic              clk,
  input  logic [MASK_W-1:0] cfgMask,
  input  logic [K-1:0]      dIn,
  input  logic              lutChainIn,
  input  logic              useLutChain,
  input  logic              regChainIn,
  input  logic              aclr,
  input  logic              apre,
  input  logic              aload,
  input  logic              aData,
  input  cellStrobes_t      strobes,
  output logic              lutOut,
  output logic              regQ
);

  logic [K-1:0] lutIdx;
  logic         dataNext;

  generate
    if (K > 1) begin : g_wide
      assign lutIdx[K-1:1] = dIn[K-1:1];
    end
  endgenerate

  assign lutIdx[0] = useLutChain ? lutChainIn : dIn[0];
  assign lutOut    = cfgMask[lutIdx];

  always_comb begin
    if (strobes.clear)       dataNext = 1'b0;
    else if (strobes.load)   dataNext = aData;
    else if (strobes.shift)  dataNext = regChainIn;
    else if (strobes.bypass) dataNext = dIn[0];
    else                     dataNext = lutOut;
  end

  always_ff @(posedge clk or posedge aclr or posedge apre or posedge aload) begin
    if (aclr)                 regQ <= 1'b0;
    else if (apre)            regQ <= 1'b1;
    else if (aload)           regQ <= aData;
    else if (strobes.capture) regQ <= dataNext;
  end

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int K = 4,
  localparam int MASK_W = 1 << K
) (
  input  logic              clk,
  input  logic [MASK_W-1:0] cfgMask,
  input  logic [K-1:0]      dIn,
  input  logic              lutChainIn,
  input  logic              useLutChain,
  input  logic              regChainIn,
  input  logic              useRegChain,
  input  logic [1:0]        mode,
  input  logic              ena,
  input  logic              sclr,
  input  logic              sload,
  input  logic              aclr,
  input  logic              apre,
  input  logic              aload,
  input  logic              aData,
  output logic              routeOut,
  output logic              localOut,
  output logic              lutChainOut,
  output logic              regChainOut,
  output logic              regFb
);

  cellStrobes_t strobes;
  logic         lutOut;
  logic         regQ;

  lut_cell_ctrl ctrl_i (
    .ena         (ena),
    .sclr        (sclr),
    .sload       (sload),
    .useRegChain (useRegChain),
    .mode        (mode),
    .strobes     (strobes)
  );

  lut_cell_dp #(.K(K)) dp_i (
    .clk         (clk),
    .cfgMask     (cfgMask),
    .dIn         (dIn),
    .lutChainIn  (lutChainIn),
    .useLutChain (useLutChain),
    .regChainIn  (regChainIn),
    .aclr        (aclr),
    .apre        (apre),
    .aload       (aload),
    .aData       (aData),
    .strobes     (strobes),
    .lutOut      (lutOut),
    .regQ        (regQ)
  );

  assign routeOut    = strobes.showReg ? regQ : lutOut;
  assign localOut    = lutOut;
  assign lutChainOut = lutOut;
  assign regChainOut = regQ;
  assign regFb       = regQ;

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk (
  input logic clk,
  input logic ena,
  input logic sclr,
  input logic sload,
  input logic aclr,
  input logic apre,
  input logic aload,
  input logic aData,
  input logic regFb,
  input logic regChainOut
);

  logic asyncAny;
  assign asyncAny = aclr | apre | aload;

  // R3: disabled enable freezes the register
  a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (asyncAny)
    !ena |=> $stable(regFb));

  // R4: synchronous clear beats every other synchronous action
  a_r4_sync_clear: assert property (@(posedge clk) disable iff (asyncAny)
    (ena && sclr) |=> (regFb == 1'b0));

  // R5: synchronous load takes the load-data input
  a_r5_sync_load: assert property (@(posedge clk) disable iff (asyncAny)
    (ena && !sclr && sload) |=> (regFb == $past(aData)));

  // R6: asynchronous clear holds the register low
  a_r6_async_clear: assert property (@(negedge clk)
    aclr |-> (regFb == 1'b0));

  // R7: asynchronous preset holds the register high
  a_r7_async_preset: assert property (@(negedge clk)
    (apre && !aclr) |-> (regFb == 1'b1));

  // R11: both register outputs agree
  a_r11_reg_outputs_agree: assert property (@(negedge clk)
    regFb == regChainOut);

endmodule

bind lut_cell lut_cell_chk chk_i (
  .clk         (clk),
  .ena         (ena),
  .sclr        (sclr),
  .sload       (sload),
  .aclr        (aclr),
  .apre        (apre),
  .aload       (aload),
  .aData       (aData),
  .regFb       (regFb),
  .regChainOut (regChainOut)
);

// File: tb/lut_cell_tb_top.sv
module lut_cell_tb_top;

  logic        clk = 1'b0;
  logic [15:0] cfgMask = '0;
  logic [3:0]  dIn = '0;
  logic        lutChainIn = 1'b0, useLutChain = 1'b0;
  logic        regChainIn = 1'b0, useRegChain = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        ena = 1'b0, sclr = 1'b0, sload = 1'b0;
  logic        aclr = 1'b0, apre = 1'b0, aload = 1'b0, aData = 1'b0;
  logic        routeOut, localOut, lutChainOut, regChainOut, regFb;

  int nCompared = 0;
  int nMismatch = 0;
  logic refQ = 1'b0;
  logic [15:0] shiftPat = 16'hB2C5;

  always #2.5 clk = ~clk;

  lut_cell dut_i (
    .clk(clk), .cfgMask(cfgMask), .dIn(dIn), .lutChainIn(lutChainIn),
    .useLutChain(useLutChain), .regChainIn(regChainIn), .useRegChain(useRegChain),
    .mode(mode), .ena(ena), .sclr(sclr), .sload(sload), .aclr(aclr), .apre(apre),
    .aload(aload), .aData(aData), .routeOut(routeOut), .localOut(localOut),
    .lutChainOut(lutChainOut), .regChainOut(regChainOut), .regFb(regFb)
  );

  function automatic logic refLut();
    int idx;
    idx = dIn[3] * 8 + dIn[2] * 4 + dIn[1] * 2 + (useLutChain ? lutChainIn : dIn[0]);
    return cfgMask[idx];
  endfunction

  task automatic check(string req, logic act, logic exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic asyncApply(logic q);
    if (aclr) return 1'b0;
    if (apre) return 1'b1;
    if (aload) return aData;
    return q;
  endfunction

  // compare all outputs, then let one rising edge pass and update the model
  task automatic tick(string req);
    logic expRoute;
    #1;
    refQ = asyncApply(refQ);
    if (useRegChain || mode == 2'd0) expRoute = refLut();
    else expRoute = refQ;
    check({req, " routeOut"}, routeOut, expRoute);
    check({req, " localOut R1"}, localOut, refLut());
    check({req, " lutChainOut R1"}, lutChainOut, refLut());
    check({req, " regFb R11"}, regFb, refQ);
    check({req, " regChainOut R11"}, regChainOut, refQ);
    @(posedge clk);
    if (aclr || apre || aload) refQ = asyncApply(refQ);
    else if (ena) begin
      if (sclr) refQ = 1'b0;
      else if (sload) refQ = aData;
      else if (useRegChain) refQ = regChainIn;
      else if (mode == 2'd2) refQ = dIn[0];
      else refQ = refLut();
    end
    @(negedge clk);
  endtask

  initial begin
    #200000;
    nMismatch++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    @(negedge clk);
    aclr = 1'b1;
    tick("R6 reset");
    tick("R6 reset hold");
    aclr = 1'b0;
    tick("R6 release");

    // R1: walk all 16 indices over two masks, combinational mode
    cfgMask = 16'h6A93;
    for (int i = 0; i < 16; i++) begin dIn = 4'(i); tick("R1 mask A"); end
    cfgMask = 16'h8001;
    for (int i = 0; i < 16; i++) begin dIn = 4'(15 - i); tick("R1 mask B"); end

    // R2: chain replaces index bit 0
    cfgMask = 16'h5555; useLutChain = 1'b1;
    for (int i = 0; i < 8; i++) begin
      dIn = 4'(i * 2 + 1); lutChainIn = i[0]; tick("R2 lut chain");
    end
    useLutChain = 1'b0;

    // R9: registered LUT, modes 1 and 3
    ena = 1'b1; cfgMask = 16'hC3A5;
    for (int m = 1; m < 4; m += 2) begin
      mode = 2'(m);
      for (int i = 0; i < 16; i++) begin dIn = 4'(i * 7); tick("R9 reg lut"); end
    end
    // R9: bypass, table ignored
    mode = 2'd2; cfgMask = 16'h0000;
    for (int i = 0; i < 10; i++) begin dIn = 4'(i * 3 + 1); tick("R9 bypass"); end

    // R3: enable low holds regardless of controls
    mode = 2'd1; cfgMask = 16'hFFFF; dIn = 4'h3; tick("R3 prime");
    ena = 1'b0; cfgMask = 16'h0000; sclr = 1'b1; tick("R3 hold sclr");
    sclr = 1'b0; sload = 1'b1; aData = 1'b0; tick("R3 hold sload");
    sload = 1'b0; tick("R3 hold data"); tick("R3 hold data 2");

    // R4: sclr beats sload and data
    ena = 1'b1; cfgMask = 16'hFFFF; tick("R4 prime");
    sclr = 1'b1; sload = 1'b1; aData = 1'b1; tick("R4 sclr over sload");
    tick("R4 after");
    sclr = 1'b0;

    // R5: sload beats chain and data
    aData = 1'b1; cfgMask = 16'h0000; useRegChain = 1'b1; regChainIn = 1'b0;
    tick("R5 sload one"); tick("R5 sload after");
    aData = 1'b0; cfgMask = 16'hFFFF; regChainIn = 1'b1;
    tick("R5 sload zero"); tick("R5 sload after 2");
    sload = 1'b0; useRegChain = 1'b0;

    // R10: shift pattern while table drives outputs
    useRegChain = 1'b1; mode = 2'd1; cfgMask = 16'h1E78;
    for (int i = 0; i < 16; i++) begin
      regChainIn = shiftPat[i]; dIn = 4'(i * 5); tick("R10 shift");
    end
    useRegChain = 1'b0;

    // R7: preset, no clock needed, beats aload
    ena = 1'b0; cfgMask = 16'h0000; tick("R7 prime");
    aclr = 1'b1; tick("R7 clear first"); aclr = 1'b0; tick("R7 clear off");
    apre = 1'b1; aload = 1'b1; aData = 1'b0; tick("R7 preset");
    ena = 1'b1; tick("R7 preset held");
    apre = 1'b0; aload = 1'b0; tick("R7 release");

    // R8: async load, reload on clock edges while held
    ena = 1'b1; mode = 2'd1; cfgMask = 16'h0000;
    aData = 1'b1; aload = 1'b1; tick("R8 aload one");
    sclr = 1'b1; tick("R8 aload over sclr"); sclr = 1'b0;
    aload = 1'b0; tick("R8 release"); tick("R8 after");
    aData = 1'b0; cfgMask = 16'hFFFF; tick("R8 set one");
    aload = 1'b1; tick("R8 aload zero"); aload = 1'b0;

    // R6: clear and preset together, clear wins; clear beats aload
    cfgMask = 16'hFFFF; tick("R6 prime");
    aclr = 1'b1; apre = 1'b1; tick("R6 clear over preset"); tick("R6 both held");
    aclr = 1'b0; apre = 1'b0; tick("R6 release");
    aData = 1'b1; aclr = 1'b1; aload = 1'b1; tick("R6 clear over aload");
    aclr = 1'b0; aload = 1'b0; tick("R6 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule